// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the hazard control for a five-stage in-order integer pipeline with these stages: fetch, decode/register read, execute, memory, writeback. It compares the source register numbers of the instructions in decode and execute with the destination numbers held in the later pipeline registers. From that comparison it produces the select codes for the two ALU operand multiplexers, the select for the store-data multiplexer in the memory stage, and a load-use interlock. The datapath, register file and memories sit outside this block.

Only read-after-write hazards are handled. Every instruction reads registers in decode and writes them in writeback, so write-after-read and write-after-write conflicts cannot arise. Register 0 is hard-wired to zero and never takes part in a forward or a stall. The register file writes in the first half of a cycle and reads in the second half. Because of this, a value being written back while decode reads the same register needs no help from this block.

When the interlock fires, the pipeline holds the PC and the fetch/decode register, and it loads a no-op with a cleared write enable into the decode/execute register. A one-bit registered guard makes sure the interlock lasts exactly one cycle per load.

Top module: `fwd_interlock_unit`

## Requirements
- R1: `fwd_a_sel`/`fwd_b_sel` equal 1 (execute/memory ALU result) when the execute/memory register writes a non-zero destination that equals that execute-stage source and is not a load. A load held in execute/memory never produces code 1.
- R2: Without an R1 match, a source that equals the non-zero destination written by the memory/writeback register selects 2 (ALU result) if that instruction is not a load, or 3 (load data) if it is. Otherwise the select is 0 (register file value).
- R3: When both later registers match the same source, the execute/memory value (code 1) wins.
- R4: A destination of register 0 never produces a forward, a store-data forward or a stall.
- R5: `stall` and `idex_bubble` are both 1 in a cycle where execute holds a load (`ex_is_load` and `ex_we` set) to a non-zero register, and decode uses that register through `id_rs1` with `id_rs1_used`, or through `id_rs2` with `id_rs2_used` on a non-store.
- R6: `stall` is 0 out of reset and is never 1 in two consecutive cycles. A hazard that is still present in the cycle after a stall is not stalled again.
- R7: A store in decode whose data register (`id_rs2`) is the loaded register does not stall. `st_data_sel` is 1 when the memory stage holds a store whose data register equals the non-zero destination written by the memory/writeback register, and 0 otherwise.
- R8: A cleared write enable on any later stage makes that stage produce no forward, no store-data forward and no stall.
- R9: Matches against the execute/memory or memory/writeback destinations never stall decode. A source flagged unused never stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | 5 | Decode first source register |
| id_rs1_used | input | 1 | Decode reads first source |
| id_rs2 | input | 5 | Decode second source register (store data for stores) |
| id_rs2_used | input | 1 | Decode reads second source |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rs1 | input | 5 | Execute first source register |
| ex_rs2 | input | 5 | Execute second source register |
| ex_rd | input | 5 | Execute destination register |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| exm_rd | input | 5 | Execute/memory destination register |
| exm_we | input | 1 | Execute/memory write enable |
| exm_is_load | input | 1 | Execute/memory instruction is a load |
| mem_st_rs2 | input | 5 | Store-data register of the memory-stage instruction |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | 5 | Memory/writeback destination register |
| wb_we | input | 1 | Memory/writeback write enable |
| wb_is_load | input | 1 | Memory/writeback instruction is a load |
| fwd_a_sel | output | 2 | ALU operand A source: 0 regfile, 1 exm ALU, 2 wb ALU, 3 wb load |
| fwd_b_sel | output | 2 | ALU operand B source, same coding |
| st_data_sel | output | 1 | Store data: 0 carried value, 1 writeback value |
| stall | output | 1 | Hold PC and fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into decode/execute |

## Verification
The bench targets several corner cases, each with a distinct failure mode:
- Both later stages match the same source. Wrong priority hands the ALU a stale value.
- A destination of register 0 is set together with a live write enable. A design that skips the zero check forwards garbage or stalls for no reason.
- A load sits in the execute/memory stage and matches an execute source. Choosing code 1 there would feed the load address in place of the load data.
- A load is followed by a store of the loaded register. A design that stalls here loses a cycle, and a design that misses the memory-stage bypass stores the old value.
- The same load-use hazard is held for two cycles. This shows that a design without the single-bubble guard would freeze decode twice.

// File: rtl/fwdunit_pkg.sv
// Shared types for the forwarding and interlock unit.
package fwdunit_pkg;

    // Operand source select codes; the datapath mux decodes these values.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXM_ALU = 2'd1,
        SRC_WB_ALU  = 2'd2,
        SRC_WB_LOAD = 2'd3
    } opnd_src_e;

endpackage

// File: rtl/operand_bypass_sel.sv
// Picks the source for one execute-stage ALU operand.
// Assumes a load in execute/memory has no data yet; the interlock keeps a
// dependent ALU use away from that slot, so such a match falls through.
module operand_bypass_sel
    import fwdunit_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] exm_rd,
    input  logic              exm_we,
    input  logic              exm_is_load,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    input  logic              wb_is_load,
    output opnd_src_e         sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic exm_hit;
    logic wb_hit;

    // Match against each later stage, excluding register 0.
    always_comb begin
        exm_hit = exm_we && !exm_is_load && (exm_rd != ZERO_REG) && (exm_rd == src);
        wb_hit  = wb_we && (wb_rd != ZERO_REG) && (wb_rd == src);
    end

    // Newer stage wins; writeback picks ALU or load data.
    always_comb begin
        if (exm_hit)
            sel = SRC_EXM_ALU;
        else if (wb_hit)
            sel = wb_is_load ? SRC_WB_LOAD : SRC_WB_ALU;
        else
            sel = SRC_REGFILE;
    end

    AST_R0_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ZERO_REG) |-> (sel == SRC_REGFILE)); // R4
    AST_NO_LOAD_ADDR_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        exm_is_load |-> (sel != SRC_EXM_ALU)); // R1
    AST_NO_WE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!exm_we && !wb_we) |-> (sel == SRC_REGFILE)); // R8

endmodule

// File: rtl/store_data_bypass.sv
// Memory-stage store-data bypass from the writeback stage.
// Assumes the writeback result bus carries load data or ALU result as needed.
module store_data_bypass #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] mem_st_rs2,
    input  logic              mem_is_store,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic              st_sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Forward when the store's data register is being written back.
    always_comb begin
        st_sel = mem_is_store && wb_we && (wb_rd != ZERO_REG) && (wb_rd == mem_st_rs2);
    end

endmodule

// File: rtl/load_use_interlock.sv
// Detects a load in execute whose result decode needs as an ALU operand.
// Store data is exempt: it is bypassed later in the memory stage.
// A registered guard limits the freeze to one cycle per load.
module load_use_interlock #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic              id_rs1_used,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs2_used,
    input  logic              id_is_store,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_we,
    input  logic              ex_is_load,
    output logic              stall
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic load_live;
    logic hazard;
    logic stall_q;

    // Raw load-use condition from decode sources against execute destination.
    always_comb begin
        load_live = ex_we && ex_is_load && (ex_rd != ZERO_REG);
        hazard    = load_live &&
                    ((id_rs1_used && (id_rs1 == ex_rd)) ||
                     (id_rs2_used && !id_is_store && (id_rs2 == ex_rd)));
        stall     = hazard && !stall_q;
    end

    // Remember a stall so the next cycle cannot stall again.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stall_q <= 1'b0;
        else
            stall_q <= stall;
    end

    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_is_load && ex_we && (ex_rd != ZERO_REG))); // R5
    AST_STORE_DATA_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_store && !(id_rs1_used && (id_rs1 == ex_rd))) |-> !stall); // R7

endmodule

// File: rtl/fwd_interlock_unit.sv
// Forwarding and interlock control for a five-stage in-order pipeline.
// Drives ALU operand selects, memory-stage store-data select and the
// load-use freeze. Assumes write-then-read register file within a cycle.
module fwd_interlock_unit
    import fwdunit_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic              id_rs1_used,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs2_used,
    input  logic              id_is_store,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_we,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] exm_rd,
    input  logic              exm_we,
    input  logic              exm_is_load,
    input  logic [REG_AW-1:0] mem_st_rs2,
    input  logic              mem_is_store,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    input  logic              wb_is_load,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              st_data_sel,
    output logic              stall,
    output logic              idex_bubble
);

    localparam int NUM_OPND = 2;

    logic [REG_AW-1:0] ex_src  [NUM_OPND];
    opnd_src_e         src_sel [NUM_OPND];
    logic              freeze;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    // One bypass selector per ALU operand.
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        operand_bypass_sel #(.REG_AW(REG_AW)) u_sel (
            .clk         (clk),
            .rst_n       (rst_n),
            .src         (ex_src[g]),
            .exm_rd      (exm_rd),
            .exm_we      (exm_we),
            .exm_is_load (exm_is_load),
            .wb_rd       (wb_rd),
            .wb_we       (wb_we),
            .wb_is_load  (wb_is_load),
            .sel         (src_sel[g])
        );
    end

    store_data_bypass #(.REG_AW(REG_AW)) u_st (
        .mem_st_rs2   (mem_st_rs2),
        .mem_is_store (mem_is_store),
        .wb_rd        (wb_rd),
        .wb_we        (wb_we),
        .st_sel       (st_data_sel)
    );

    load_use_interlock #(.REG_AW(REG_AW)) u_lu (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_rs1      (id_rs1),
        .id_rs1_used (id_rs1_used),
        .id_rs2      (id_rs2),
        .id_rs2_used (id_rs2_used),
        .id_is_store (id_is_store),
        .ex_rd       (ex_rd),
        .ex_we       (ex_we),
        .ex_is_load  (ex_is_load),
        .stall       (freeze)
    );

    // Present selects and the freeze on the ports.
    always_comb begin
        fwd_a_sel   = src_sel[0];
        fwd_b_sel   = src_sel[1];
        stall       = freeze;
        idex_bubble = freeze;
    end

    AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> !idex_bubble); // R6
    AST_ST_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        st_data_sel |-> (mem_is_store && wb_we && (wb_rd != '0))); // R7
    AST_WB_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_we |-> !stall); // R9

endmodule

// File: tb/fwd_interlock_unit_test.sv
// Bench: directed corners plus seeded random stimulus, checked by models.
module fwd_interlock_unit_test;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, mem_st_rs2, wb_rd;
    logic id_rs1_used, id_rs2_used, id_is_store, ex_we, ex_is_load;
    logic exm_we, exm_is_load, mem_is_store, wb_we, wb_is_load;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic st_data_sel, stall, idex_bubble;

    fwd_interlock_unit #(.REG_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs1_used(id_rs1_used), .id_rs2(id_rs2),
        .id_rs2_used(id_rs2_used), .id_is_store(id_is_store),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
        .ex_is_load(ex_is_load), .exm_rd(exm_rd), .exm_we(exm_we),
        .exm_is_load(exm_is_load), .mem_st_rs2(mem_st_rs2),
        .mem_is_store(mem_is_store), .wb_rd(wb_rd), .wb_we(wb_we),
        .wb_is_load(wb_is_load), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .st_data_sel(st_data_sel), .stall(stall), .idex_bubble(idex_bubble)
    );

    int checks = 0;
    int fails = 0;
    logic model_prev = 1'b0;
    bit done = 0;

    function automatic int exp_sel(logic [AW-1:0] s);
        if (exm_we && !exm_is_load && exm_rd != 0 && exm_rd == s) return 1;
        if (wb_we && wb_rd != 0 && wb_rd == s) return wb_is_load ? 3 : 2;
        return 0;
    endfunction

    function automatic string sel_tag(logic [AW-1:0] s);
        bit wbm;
        wbm = wb_we && wb_rd != 0 && wb_rd == s;
        if (exp_sel(s) == 1) return wbm ? "R3" : "R1";
        if (exp_sel(s) >= 2) return "R2";
        if (s == 0) return "R4";
        return "R8";
    endfunction

    function automatic logic exp_hazard();
        return ex_we && ex_is_load && ex_rd != 0 &&
               ((id_rs1_used && id_rs1 == ex_rd) ||
                (id_rs2_used && !id_is_store && id_rs2 == ex_rd));
    endfunction

    function automatic logic exp_st();
        return mem_is_store && wb_we && wb_rd != 0 && wb_rd == mem_st_rs2;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare outputs mid-cycle, then advance the stall model one edge.
    task automatic sample();
        logic es;
        string st;
        #2;
        es = exp_hazard() && !model_prev;
        st = es ? "R5" : ((exp_hazard() && model_prev) ? "R6" : "R9");
        chk(sel_tag(ex_rs1), int'(fwd_a_sel), exp_sel(ex_rs1), "fwd_a_sel");
        chk(sel_tag(ex_rs2), int'(fwd_b_sel), exp_sel(ex_rs2), "fwd_b_sel");
        chk(st, int'(stall), int'(es), "stall");
        chk("R5", int'(idex_bubble), int'(es), "idex_bubble");
        chk("R7", int'(st_data_sel), int'(exp_st()), "st_data_sel");
        @(posedge clk);
        model_prev = rst_n ? es : 1'b0;
        #1;
    endtask

    task automatic clear_in();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, mem_st_rs2, wb_rd} = '0;
        {id_rs1_used, id_rs2_used, id_is_store, ex_we, ex_is_load} = '0;
        {exm_we, exm_is_load, mem_is_store, wb_we, wb_is_load} = '0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        clear_in();
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R6: reset state, all outputs idle
        sample();

        // R1: ALU result one ahead forwards on operand A
        clear_in(); ex_rs1 = 5'd3; exm_rd = 5'd3; exm_we = 1; sample();
        // R2: writeback ALU and load sources on operand B
        clear_in(); ex_rs2 = 5'd7; wb_rd = 5'd7; wb_we = 1; sample();
        wb_is_load = 1; sample();
        // R3: both stages match, newer wins
        clear_in(); ex_rs1 = 5'd4; exm_rd = 5'd4; exm_we = 1; wb_rd = 5'd4; wb_we = 1; sample();
        // R4: register 0 destinations
        clear_in(); exm_rd = 0; exm_we = 1; wb_we = 1; ex_we = 1; ex_is_load = 1;
        id_rs1_used = 1; mem_is_store = 1; sample();
        // R8: write enables cleared
        clear_in(); ex_rs1 = 5'd9; exm_rd = 5'd9; wb_rd = 5'd9; ex_rd = 5'd9;
        ex_is_load = 1; id_rs1 = 5'd9; id_rs1_used = 1; mem_is_store = 1; mem_st_rs2 = 5'd9; sample();
        // R1: load in execute/memory never forwards its address
        clear_in(); ex_rs1 = 5'd5; exm_rd = 5'd5; exm_we = 1; exm_is_load = 1; sample();
        // R5 then R6: load-use stalls once even if held
        clear_in(); ex_rd = 5'd6; ex_we = 1; ex_is_load = 1; id_rs2 = 5'd6; id_rs2_used = 1; sample();
        sample();
        sample();
        // R7: load followed by store of loaded data, then memory-stage bypass
        clear_in(); ex_rd = 5'd8; ex_we = 1; ex_is_load = 1; id_is_store = 1;
        id_rs1 = 5'd2; id_rs1_used = 1; id_rs2 = 5'd8; id_rs2_used = 1; sample();
        clear_in(); mem_is_store = 1; mem_st_rs2 = 5'd8; wb_rd = 5'd8; wb_we = 1; wb_is_load = 1; sample();
        // R9: unused source and later-stage matches never stall
        clear_in(); ex_rd = 5'd1; ex_we = 1; ex_is_load = 1; id_rs1 = 5'd1; sample();
        clear_in(); exm_rd = 5'd2; exm_we = 1; exm_is_load = 1; id_rs1 = 5'd2; id_rs1_used = 1;
        wb_rd = 5'd3; wb_we = 1; id_rs2 = 5'd3; id_rs2_used = 1; sample();

        // Random mix over a small register range to provoke matches.
        for (int i = 0; i < 4000; i++) begin
            id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
            ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
            ex_rd = AW'($urandom_range(0, 3)); exm_rd = AW'($urandom_range(0, 3));
            wb_rd = AW'($urandom_range(0, 3)); mem_st_rs2 = AW'($urandom_range(0, 3));
            {id_rs1_used, id_rs2_used, id_is_store, ex_we, ex_is_load} = 5'($urandom);
            {exm_we, exm_is_load, mem_is_store, wb_we, wb_is_load} = 5'($urandom);
            if (i % 500 == 250) begin
                rst_n = 1'b0;
                sample();
                rst_n = 1'b1;
            end else begin
                sample();
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule